// File: doc/BRIEF.md
# SPI Control and Interrupt Register Slave

This block is a serial slave that gives a host controller access to a small set of control and status registers over 16-bit full-duplex frames. Each frame opens with an active-low chip select. The first three bits received pick one of four registers. The fourth bit says whether the frame only reads. The last twelve bits carry the payload. While the host shifts its frame in, the slave shifts out the contents the addressed register held before the frame. A write takes effect only when chip select rises after exactly sixteen serial clocks.

The registers hold control fields for neighbouring logic: a watchdog period and mode, an operating-mode selector with a limp-home warning flag and five miscellaneous enables, wake-input configuration fields, and interrupt enables. One register collects event pulses from that logic as pending interrupt flags. Software clears a flag by writing 1 to it. A registered, active-low interrupt line is low while any enabled flag is pending.

All serial inputs are resynchronised into the system clock domain. The system clock must run at least eight times faster than the serial clock.

Top module: `spi_ctrl_regs`

## Requirements
- R1: After reset, wd_mode is 0, wd_period is 3'b100, op_mode is 2'b00, limp_warn is 1, ctl_misc, wake_cfg_a, wake_cfg_b and wake_samp are all 0, no interrupt is pending and irq_n is 1.
- R2: Frame bits 15:13 select the register: 000 watchdog/status, 001 mode, 010 interrupt enable, 011 interrupt pending. Bits are sent MSB first, and the 12-bit register image comes back on response bits 11:0. Response bits 15:12 are 0.
- R3: A frame with bit 12 set changes no register.
- R4: A 16-clock frame with bit 12 clear writes its payload. Watchdog: bit 11 = wd_mode, bits 10:8 = wd_period. Mode: bits 11:10 = op_mode, bit 9 = limp_warn, bits 8:4 = ctl_misc. Interrupt enable: bits 11:8 = enables for events 3..0, bits 7:6 = wake_cfg_a, bits 5:4 = wake_cfg_b, bit 1 = wake_samp[1], bit 0 = wake_samp[0].
- R5: A frame where chip select rises after any count of serial clocks other than 16 writes nothing.
- R6: The response of a frame carries the register contents from before that frame's own write.
- R7: In the pending register (bits 11:8 = events 3..0), writing 1 to a bit clears it and writing 0 leaves it unchanged. Without a write to that register, no flag clears.
- R8: An event pulse in the same cycle as a clear of its flag wins, so the flag stays set.
- R9: irq_n is low, one cycle after the state arises, exactly while some pending flag has its enable bit set.
- R10: sdo is high-impedance while chip select is high.
- R11: Reserved bits and addresses 100 to 111 read as 0, and writes to them change nothing.
- R12: The watchdog register returns the live status inputs on bits 7:4, and writes cannot change them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host, idle low |
| csn | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host, high-impedance when deselected |
| sts_i | input | 4 | Level status inputs shown in the watchdog register |
| evt_i | input | 4 | Event pulses that set pending flags |
| wd_mode | output | 1 | Watchdog mode control |
| wd_period | output | 3 | Watchdog period code |
| op_mode | output | 2 | Operating-mode selector |
| limp_warn | output | 1 | Limp-home warning flag |
| ctl_misc | output | 5 | Miscellaneous control enables |
| wake_cfg_a | output | 2 | Wake input A configuration |
| wake_cfg_b | output | 2 | Wake input B configuration |
| wake_samp | output | 2 | Wake sampling enables |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Assertions check on every cycle that an event always leaves its flag set (R8), that flags never clear without a write to the pending register (R7), that irq_n tracks pending-and-enabled flags one cycle later (R9), that mode writes land as sent (R4), and that short, long or read-only frames raise no write (R3, R5). Only the bench's serial scenarios can show the serial behaviour. That covers the address decode and bit order on sdo, the pre-write snapshot in the response, reserved bits reading 0, and the release of sdo between frames. It also covers irq_n rising again only after software clears the flag.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 3;
  localparam int HDR_W   = ADDR_W + 1;
  localparam int DATA_W  = FRAME_W - HDR_W;
  localparam int NEVT    = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_WDOG  = 3'd0,
    A_MODE  = 3'd1,
    A_IEN   = 3'd2,
    A_ISTAT = 3'd3
  } reg_addr_e;
endpackage

// File: rtl/spi_frame_if.sv
module spi_frame_if
  import spi_regs_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              csn,
  input  logic              sdi,
  output logic              sdo_q,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(FW + 2);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FW + 1);
  localparam logic [CNT_W-1:0] CNT_SNAP = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam int RO_BIT = FW - ADDR_W - 1;

  logic [2:0] sck_p, csn_p;
  logic [1:0] sdi_p;
  logic sck_rise, sck_fall, cs_rise, cs_fall, active;
  logic [CNT_W-1:0] cnt;
  logic [FW-1:0] rx;
  logic [DATA_W-1:0] snap;
  logic [CNT_W-1:0] out_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      csn_p <= '1;
      sdi_p <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      csn_p <= {csn_p[1:0], csn};
      sdi_p <= {sdi_p[0], sdi};
    end
  end

  assign sck_rise = sck_p[1] & ~sck_p[2];
  assign sck_fall = ~sck_p[1] & sck_p[2];
  assign cs_rise  = csn_p[1] & ~csn_p[2];
  assign cs_fall  = ~csn_p[1] & csn_p[2];
  assign active   = ~csn_p[1];
  assign sdo_oe   = active;
  assign rd_addr  = {rx[ADDR_W-2:0], sdi_p[1]};
  assign out_idx  = CNT_W'(FW - 1) - cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rx      <= '0;
      snap    <= '0;
      sdo_q   <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (cs_fall) begin
        cnt   <= '0;
        sdo_q <= 1'b0;
      end else if (active && sck_rise) begin
        rx <= {rx[FW-2:0], sdi_p[1]};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        if (cnt == CNT_SNAP) snap <= rd_data;
      end else if (active && sck_fall) begin
        if (cnt >= CNT_HDR && cnt < CNT_FULL) sdo_q <= snap[out_idx[IDX_W-1:0]];
        else sdo_q <= 1'b0;
      end
      if (cs_rise) begin
        wr_en   <= (cnt == CNT_FULL) && !rx[RO_BIT];
        wr_addr <= rx[FW-1 -: ADDR_W];
        wr_data <= rx[DATA_W-1:0];
      end
    end
  end

  assert_short_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && cnt != CNT_FULL) |=> !wr_en);
  assert_ro_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && rx[RO_BIT]) |=> !wr_en);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NEVT-1:0]   sts_i,
  input  logic [NEVT-1:0]   evt_i,
  output logic              wd_mode,
  output logic [2:0]        wd_period,
  output logic [1:0]        op_mode,
  output logic              limp_warn,
  output logic [4:0]        ctl_misc,
  output logic [1:0]        wake_cfg_a,
  output logic [1:0]        wake_cfg_b,
  output logic [1:0]        wake_samp,
  output logic              irq_n
);
  localparam int EVT_LSB = DATA_W - NEVT;

  logic [NEVT-1:0] en_q, pend_q, pend_nxt;
  logic wr_wdog, wr_mode, wr_ien, wr_istat;

  assign wr_wdog  = wr_en && wr_addr == A_WDOG;
  assign wr_mode  = wr_en && wr_addr == A_MODE;
  assign wr_ien   = wr_en && wr_addr == A_IEN;
  assign wr_istat = wr_en && wr_addr == A_ISTAT;

  for (genvar i = 0; i < NEVT; i++) begin : g_pend
    assign pend_nxt[i] = evt_i[i] | (pend_q[i] & ~(wr_istat & wr_data[EVT_LSB+i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_mode    <= 1'b0;
      wd_period  <= 3'b100;
      op_mode    <= 2'b00;
      limp_warn  <= 1'b1;
      ctl_misc   <= '0;
      en_q       <= '0;
      wake_cfg_a <= '0;
      wake_cfg_b <= '0;
      wake_samp  <= '0;
      pend_q     <= '0;
      irq_n      <= 1'b1;
    end else begin
      if (wr_wdog) begin
        wd_mode   <= wr_data[11];
        wd_period <= wr_data[10:8];
      end
      if (wr_mode) begin
        op_mode   <= wr_data[11:10];
        limp_warn <= wr_data[9];
        ctl_misc  <= wr_data[8:4];
      end
      if (wr_ien) begin
        en_q       <= wr_data[11:8];
        wake_cfg_a <= wr_data[7:6];
        wake_cfg_b <= wr_data[5:4];
        wake_samp  <= wr_data[1:0];
      end
      pend_q <= pend_nxt;
      irq_n  <= ~|(pend_q & en_q);
    end
  end

  always_comb begin
    case (rd_addr)
      A_WDOG:  rd_data = {wd_mode, wd_period, sts_i, 4'b0000};
      A_MODE:  rd_data = {op_mode, limp_warn, ctl_misc, 4'b0000};
      A_IEN:   rd_data = {en_q, wake_cfg_a, wake_cfg_b, 2'b00, wake_samp};
      A_ISTAT: rd_data = {pend_q, 8'h00};
      default: rd_data = '0;
    endcase
  end

  assert_evt_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));
  assert_no_spont_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_istat |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_n == ~|($past(pend_q) & $past(en_q))));
  assert_mode_commit_R4: assert property (@(posedge clk) disable iff (rst)
    wr_mode |=> (op_mode == $past(wr_data[11:10])));
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       csn,
  input  logic       sdi,
  output logic       sdo,
  input  logic [3:0] sts_i,
  input  logic [3:0] evt_i,
  output logic       wd_mode,
  output logic [2:0] wd_period,
  output logic [1:0] op_mode,
  output logic       limp_warn,
  output logic [4:0] ctl_misc,
  output logic [1:0] wake_cfg_a,
  output logic [1:0] wake_cfg_b,
  output logic [1:0] wake_samp,
  output logic       irq_n
);
  logic sdo_q, sdo_oe, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  spi_frame_if #(.FW(FRAME_W)) u_frame (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .sdi(sdi),
    .sdo_q(sdo_q), .sdo_oe(sdo_oe),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  spi_reg_bank u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sts_i(sts_i), .evt_i(evt_i),
    .wd_mode(wd_mode), .wd_period(wd_period),
    .op_mode(op_mode), .limp_warn(limp_warn), .ctl_misc(ctl_misc),
    .wake_cfg_a(wake_cfg_a), .wake_cfg_b(wake_cfg_b), .wake_samp(wake_samp),
    .irq_n(irq_n)
  );

  assign sdo = sdo_oe ? sdo_q : 1'bz;
endmodule

// File: tb/spi_ctrl_regs_test.sv
module spi_ctrl_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic [3:0] sts_i = '0, evt_i = '0;
  wire sdo;
  logic wd_mode, limp_warn, irq_n;
  logic [2:0] wd_period;
  logic [1:0] op_mode, wake_cfg_a, wake_cfg_b, wake_samp;
  logic [4:0] ctl_misc;
  int checks = 0, errors = 0;
  logic [15:0] resp;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ctrl_regs uut (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .sdi(sdi), .sdo(sdo),
    .sts_i(sts_i), .evt_i(evt_i), .wd_mode(wd_mode), .wd_period(wd_period),
    .op_mode(op_mode), .limp_warn(limp_warn), .ctl_misc(ctl_misc),
    .wake_cfg_a(wake_cfg_a), .wake_cfg_b(wake_cfg_b), .wake_samp(wake_samp),
    .irq_n(irq_n)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? tx[15-i] : 1'b0;
      wait_clk(HALF);
      if (i < 16) rx[15-i] = sdo;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [15:0] rx);
    xfer({a, 1'b1, 12'h000}, 16, rx);
  endtask

  task automatic t_reset;
    check("R1 wd", {12'h0, wd_mode, wd_period}, 16'h0004);
    check("R1 mode", {8'h0, op_mode, limp_warn, ctl_misc}, 16'h0020);
    check("R1 wake", {10'h0, wake_cfg_a, wake_cfg_b, wake_samp}, 16'h0000);
    check("R1 irq_n", {15'h0, irq_n}, 16'h0001);
    check("R10 sdo idle", {15'h0, sdo}, {15'h0, 1'bz});
    read_reg(3'b010, resp);
    check("R1 ien read", resp, 16'h0000);
  endtask

  task automatic t_read_status;
    sts_i = 4'b1010;
    read_reg(3'b000, resp);
    check("R2 R12 wdog read", resp, 16'h04A0);
    sts_i = 4'b0000;
  endtask

  task automatic t_write_mode;
    xfer({3'b001, 1'b0, 2'b10, 1'b0, 5'b10101, 4'hF}, 16, resp);
    check("R6 pre-write image", resp, 16'h0200);
    check("R4 mode outputs", {8'h0, op_mode, limp_warn, ctl_misc}, 16'h0095);
    read_reg(3'b001, resp);
    check("R11 R2 mode read", resp, 16'h0950);
  endtask

  task automatic t_read_only;
    xfer({3'b001, 1'b1, 12'h3F0}, 16, resp);
    check("R3 ro frame", {8'h0, op_mode, limp_warn, ctl_misc}, 16'h0095);
  endtask

  task automatic t_bad_length;
    xfer({3'b001, 1'b0, 12'h3F0}, 15, resp);
    check("R5 short frame", {8'h0, op_mode, limp_warn, ctl_misc}, 16'h0095);
    xfer({3'b001, 1'b0, 12'h3F0}, 17, resp);
    check("R5 long frame", {8'h0, op_mode, limp_warn, ctl_misc}, 16'h0095);
  endtask

  task automatic t_wdog;
    xfer({3'b000, 1'b0, 1'b1, 3'b011, 8'hFF}, 16, resp);
    check("R4 wdog outputs", {12'h0, wd_mode, wd_period}, 16'h000B);
    read_reg(3'b000, resp);
    check("R12 R11 wdog read", resp, 16'h0B00);
  endtask

  task automatic t_irq;
    xfer({3'b010, 1'b0, 4'b0101, 2'b11, 2'b01, 2'b11, 2'b11}, 16, resp);
    check("R4 ien outputs", {10'h0, wake_cfg_a, wake_cfg_b, wake_samp}, 16'h0037);
    evt_i = 4'b0010; wait_clk(1); evt_i = 4'b0000; wait_clk(3);
    check("R9 masked event", {15'h0, irq_n}, 16'h0001);
    evt_i = 4'b0100; wait_clk(1); evt_i = 4'b0000; wait_clk(3);
    check("R9 enabled event", {15'h0, irq_n}, 16'h0000);
    read_reg(3'b011, resp);
    check("R2 pending read", resp, 16'h0600);
    xfer({3'b011, 1'b0, 12'h0FF}, 16, resp);
    read_reg(3'b011, resp);
    check("R7 write zero", resp, 16'h0600);
    xfer({3'b011, 1'b0, 12'h400}, 16, resp);
    read_reg(3'b011, resp);
    check("R7 clear one", resp, 16'h0200);
    check("R9 irq released", {15'h0, irq_n}, 16'h0001);
    evt_i = 4'b0010;
    xfer({3'b011, 1'b0, 12'h200}, 16, resp);
    wait_clk(4);
    evt_i = 4'b0000;
    read_reg(3'b011, resp);
    check("R8 event over clear", resp, 16'h0200);
  endtask

  task automatic t_unused_addr;
    xfer({3'b101, 1'b0, 12'hFFF}, 16, resp);
    read_reg(3'b101, resp);
    check("R11 unused addr", resp, 16'h0000);
    read_reg(3'b001, resp);
    check("R11 neighbour intact", resp, 16'h0950);
    check("R10 sdo after frame", {15'h0, sdo}, {15'h0, 1'bz});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    t_reset();
    t_read_status();
    t_write_mode();
    t_read_only();
    t_bad_length();
    t_wdog();
    t_irq();
    t_unused_addr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule